// File: doc/BRIEF.md
# Multi-Queue Transmit Channel Scheduler

This block chooses which of sixteen circular transmit queues is served next and routes each chosen descriptor index to one of eight DMA channels. Each queue is bound to exactly one channel, but several queues may share a channel. The host programs the queues through a small register port. It writes each queue's status word, write index and starting read index. The scheduler itself advances the read index as descriptors are handed out.

Every channel has its own request/acknowledge pair, and each request carries a queue number and a descriptor index. Only one transfer completes per cycle, and the highest-numbered acknowledged channel wins (channel 3, voice, ranks above 2, 1 and 0). Within a channel the queues take turns in round-robin order.

A queue works in one of two modes. In in-order mode, every accepted descriptor moves the read index on. In acknowledgement-tracking mode, the read index marks the start of a window and does not move. That queue then hands out one descriptor each time the host re-arms its window-space flag.

The control is a two-state machine. In ST_SCAN, the picks for every channel are latched during a cycle with no register write. The transition ST_SCAN→ST_OFFER is taken when at least one channel has a candidate; otherwise the machine stays in ST_SCAN. In ST_OFFER, the requests are raised. The transition ST_OFFER→ST_SCAN is taken on an accepted transfer or on any register write; otherwise the machine stays in ST_OFFER.

Top module: `txsched`

## Requirements
- R1: After reset, the channel-enable register reads 0xFF, the empty register reads 0xFFFF and the chain register reads 0. Every per-queue word reads 0, and no request is raised.
- R2: Register map: `reg_addr[5:4]` selects the region (0 global, 1 write index, 2 read index, 3 status) and `reg_addr[3:0]` selects the queue. Within the global region, the low address selects the register: 0 enable, 1 empty, 2 chain. In a status write, data bit b (b in 0..9) is stored only when data bit b+10 is 1. A status read returns bits 9:0, with zeros above.
- R3: Status fields: bit 0 marks the queue active, bits 3:1 give the bound channel (bit 4 is stored but ignored), bit 5 is window-space-left and bit 8 selects acknowledgement-tracking mode (1) or in-order mode (0).
- R4: `ch_req[c]` is raised only if bit c of the enable register is 1.
- R5: An in-order queue is a candidate on its bound channel when it is active and its write index differs from its read index. The offered `ch_index` equals its read index.
- R6: Acceptance is `ch_req[c] & ch_ack[c]`. An accept from an in-order queue increments that queue's 8-bit read index by one and raises `rd_adv[q]` during the accepting cycle.
- R7: Among the candidates on one channel, the search starts at the queue after the last accepted one and wraps around. After reset, the search on every channel starts at queue 0.
- R8: When several channels are acknowledged in the same cycle, only the highest-numbered one is accepted. The others keep their requests.
- R9: An acknowledgement-tracking queue is a candidate only while its window-space bit and its chain-select bit are both 1. Its accept clears the window-space bit, leaves the read index unchanged and raises no `rd_adv`.
- R10: A write to the empty register changes flag q (bits 15:0) only where mask bit q+16 is 1. An in-order accept that makes the read index equal to the write index sets flag q.
- R11: If a host write and an accept update the same field in one cycle, the host value is kept.
- R12: Requests appear on the second clock edge after the last register write. After an accept, all requests are low for at least one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register address (region, queue) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| ch_req | output | 8 | Per-channel request |
| ch_ack | input | 8 | Per-channel acknowledge |
| ch_queue | output | 32 | Per-channel queue number, 4 bits per channel |
| ch_index | output | 64 | Per-channel descriptor index, 8 bits per channel |
| rd_adv | output | 16 | Per-queue read-advance pulse |

## Verification
Two functions can land in the same cycle: a host register write and a descriptor accept. Both may target the read index of one queue. The bench provokes this by raising a channel's acknowledge on the same clock edge as a host write of a new read index to the queue being offered. It then judges the result in three ways. The accepted descriptor must carry the old index. The pulse must still appear. The next grant and the read-back must both show the host value, not the incremented one.

// File: rtl/txs_pkg.sv
package txs_pkg;
    // status word bit positions
    localparam int ST_ACT   = 0;
    localparam int ST_CHAN  = 1;
    localparam int ST_WSL   = 5;
    localparam int ST_MODE  = 8;
    localparam int ST_BITS  = 10;
    localparam int ST_WEN   = 10;

    // address regions
    localparam logic [1:0] RG_GLOBAL = 2'd0;
    localparam logic [1:0] RG_WRIDX  = 2'd1;
    localparam logic [1:0] RG_RDIDX  = 2'd2;
    localparam logic [1:0] RG_STATUS = 2'd3;

    // global registers
    localparam int GL_CHEN  = 0;
    localparam int GL_EMPTY = 1;
    localparam int GL_CHAIN = 2;

    typedef enum logic [0:0] {
        ST_SCAN  = 1'b0,
        ST_OFFER = 1'b1
    } sched_state_e;
endpackage

// File: rtl/txs_rr_pick.sv
module txs_rr_pick #(
    parameter int N  = 16,
    parameter int QW = $clog2(N)
) (
    input  logic [N-1:0]  elig,
    input  logic [QW-1:0] last,
    output logic [QW-1:0] pick,
    output logic          found
);
    always_comb begin
        found = 1'b0;
        pick  = last;
        for (int k = 1; k <= N; k++) begin
            int idx;
            idx = (int'(last) + k) % N;
            if (!found && elig[idx]) begin
                found = 1'b1;
                pick  = QW'(idx);
            end
        end
    end
endmodule

// File: rtl/txs_prio_pick.sv
module txs_prio_pick #(
    parameter int N  = 8,
    parameter int CW = $clog2(N)
) (
    input  logic [N-1:0]  hits,
    output logic [CW-1:0] win,
    output logic          any
);
    always_comb begin
        win = '0;
        any = |hits;
        for (int c = 0; c < N; c++) begin
            if (hits[c]) win = CW'(c);
        end
    end
endmodule

// File: rtl/txsched.sv
module txsched
    import txs_pkg::*;
#(
    parameter int NQ   = 16,
    parameter int NCH  = 8,
    parameter int IDXW = 8,
    localparam int QW  = $clog2(NQ),
    localparam int CW  = $clog2(NCH),
    localparam int AW  = QW + 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_we,
    input  logic [AW-1:0]        reg_addr,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    output logic [NCH-1:0]       ch_req,
    input  logic [NCH-1:0]       ch_ack,
    output logic [NCH*QW-1:0]    ch_queue,
    output logic [NCH*IDXW-1:0]  ch_index,
    output logic [NQ-1:0]        rd_adv
);
    sched_state_e state_q, state_nxt;

    logic [NCH-1:0]     chan_en_q;
    logic [NQ-1:0]      empty_q, chain_q;
    logic [IDXW-1:0]    wr_q [NQ];
    logic [IDXW-1:0]    rd_q [NQ];
    logic [ST_BITS-1:0] stat_q [NQ];
    logic [QW-1:0]      last_q [NCH];
    logic [QW-1:0]      offer_q [NCH];
    logic [NCH-1:0]     offer_v;

    logic [NQ-1:0]      elig_ch [NCH];
    logic [QW-1:0]      pick_q [NCH];
    logic [NCH-1:0]     pick_v;
    logic [NCH-1:0]     hits;
    logic [CW-1:0]      win_c;
    logic               acc;
    logic [QW-1:0]      acc_q;
    logic               acc_ack_mode;
    logic [IDXW-1:0]    rd_nxt;
    logic [NQ*IDXW-1:0] rd_flat;

    wire [1:0]    rg  = reg_addr[AW-1:QW];
    wire [QW-1:0] rq  = reg_addr[QW-1:0];

    // eligibility, split by bound channel
    always_comb begin
        for (int c = 0; c < NCH; c++) elig_ch[c] = '0;
        for (int q = 0; q < NQ; q++) begin
            logic [CW-1:0] b;
            logic ok;
            b  = stat_q[q][ST_CHAN +: CW];
            ok = stat_q[q][ST_ACT] && (wr_q[q] != rd_q[q]) && chan_en_q[b] &&
                 (!stat_q[q][ST_MODE] || (stat_q[q][ST_WSL] && chain_q[q]));
            elig_ch[b][q] = ok;
            rd_flat[q*IDXW +: IDXW] = rd_q[q];
        end
    end

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        txs_rr_pick #(.N(NQ), .QW(QW)) u_rr (
            .elig  (elig_ch[c]),
            .last  (last_q[c]),
            .pick  (pick_q[c]),
            .found (pick_v[c])
        );
        assign ch_queue[c*QW +: QW]     = offer_q[c];
        assign ch_index[c*IDXW +: IDXW] = rd_q[offer_q[c]];
    end

    txs_prio_pick #(.N(NCH), .CW(CW)) u_prio (
        .hits (hits),
        .win  (win_c),
        .any  (acc)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_SCAN;
        else        state_q <= state_nxt;
    end

    // next state and outputs
    always_comb begin
        ch_req       = (state_q == ST_OFFER) ? (offer_v & chan_en_q) : '0;
        hits         = ch_req & ch_ack;
        acc_q        = offer_q[win_c];
        acc_ack_mode = stat_q[acc_q][ST_MODE];
        rd_nxt       = rd_q[acc_q] + IDXW'(1);
        rd_adv       = (acc && !acc_ack_mode) ? (NQ'(1) << acc_q) : '0;
        state_nxt    = state_q;
        unique case (state_q)
            ST_SCAN:  if (!reg_we && |pick_v) state_nxt = ST_OFFER;
            ST_OFFER: if (acc || reg_we)      state_nxt = ST_SCAN;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chan_en_q <= '1;
            empty_q   <= '1;
            chain_q   <= '0;
            offer_v   <= '0;
            for (int q = 0; q < NQ; q++) begin
                wr_q[q]   <= '0;
                rd_q[q]   <= '0;
                stat_q[q] <= '0;
            end
            for (int c = 0; c < NCH; c++) begin
                last_q[c]  <= QW'(NQ - 1);
                offer_q[c] <= '0;
            end
        end else begin
            if (state_q == ST_SCAN && !reg_we) begin
                offer_v <= pick_v;
                for (int c = 0; c < NCH; c++) offer_q[c] <= pick_q[c];
            end
            if (acc) begin
                last_q[win_c] <= acc_q;
                if (!acc_ack_mode) begin
                    rd_q[acc_q] <= rd_nxt;
                    if (rd_nxt == wr_q[acc_q]) empty_q[acc_q] <= 1'b1;
                end else begin
                    stat_q[acc_q][ST_WSL] <= 1'b0;
                end
            end
            // host writes come last so they win over the accept
            if (reg_we) begin
                unique case (rg)
                    RG_GLOBAL: begin
                        if (int'(rq) == GL_CHEN) chan_en_q <= reg_wdata[NCH-1:0];
                        if (int'(rq) == GL_CHAIN) chain_q <= reg_wdata[NQ-1:0];
                        if (int'(rq) == GL_EMPTY)
                            for (int q = 0; q < NQ; q++)
                                if (reg_wdata[16+q]) empty_q[q] <= reg_wdata[q];
                    end
                    RG_WRIDX: wr_q[rq] <= reg_wdata[IDXW-1:0];
                    RG_RDIDX: rd_q[rq] <= reg_wdata[IDXW-1:0];
                    RG_STATUS:
                        for (int b = 0; b < ST_BITS; b++)
                            if (reg_wdata[ST_WEN+b]) stat_q[rq][b] <= reg_wdata[b];
                endcase
            end
        end
    end

    // register read
    always_comb begin
        reg_rdata = '0;
        unique case (rg)
            RG_GLOBAL: begin
                if (int'(rq) == GL_CHEN)  reg_rdata = 32'(chan_en_q);
                if (int'(rq) == GL_EMPTY) reg_rdata = 32'(empty_q);
                if (int'(rq) == GL_CHAIN) reg_rdata = 32'(chain_q);
            end
            RG_WRIDX:  reg_rdata = 32'(wr_q[rq]);
            RG_RDIDX:  reg_rdata = 32'(rd_q[rq]);
            RG_STATUS: reg_rdata = 32'(stat_q[rq]);
        endcase
    end
endmodule

// File: rtl/txsched_chk.sv
module txsched_chk #(
    parameter int NQ   = 16,
    parameter int NCH  = 8,
    parameter int IDXW = 8,
    localparam int QW  = $clog2(NQ)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                reg_we,
    input logic [NCH-1:0]      ch_req,
    input logic [NCH-1:0]      ch_ack,
    input logic [NCH*QW-1:0]   ch_queue,
    input logic [NCH-1:0]      chan_en,
    input logic [NQ-1:0]       rd_adv,
    input logic [NQ*IDXW-1:0]  rd_flat
);
    AST_REQ_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_req & ~chan_en) == '0);                                          // R4
    AST_ADV_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rd_adv));                                                   // R8
    AST_ADV_HAS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        |rd_adv |-> |(ch_req & ch_ack));                                     // R6
    AST_IDLE_AFTER_ACC: assert property (@(posedge clk) disable iff (!rst_n)
        |(ch_req & ch_ack) |=> ch_req == '0);                                // R12

    for (genvar c = 0; c < NCH; c++) begin : g_hold
        AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_req[c] && !(|(ch_req & ch_ack)) && !reg_we) |=>
            (ch_req[c] && $stable(ch_queue[c*QW +: QW])));                   // R8
    end

    for (genvar q = 0; q < NQ; q++) begin : g_step
        AST_RD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_adv[q] && !reg_we) |=>
            rd_flat[q*IDXW +: IDXW] == IDXW'($past(rd_flat[q*IDXW +: IDXW]) + 1)); // R6
    end
endmodule

bind txsched txsched_chk #(.NQ(NQ), .NCH(NCH), .IDXW(IDXW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_we   (reg_we),
    .ch_req   (ch_req),
    .ch_ack   (ch_ack),
    .ch_queue (ch_queue),
    .chan_en  (chan_en_q),
    .rd_adv   (rd_adv),
    .rd_flat  (rd_flat)
);

// File: tb/tb_txsched.sv
module tb_txsched;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [7:0]  ch_req;
    logic [7:0]  ch_ack = '0;
    logic [31:0] ch_queue;
    logic [63:0] ch_index;
    logic [15:0] rd_adv;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    typedef struct { int ch; int q; int idx; bit adv; } exp_t;
    exp_t sb [$];

    always #5 clk = ~clk;

    txsched dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ch_req(ch_req),
        .ch_ack(ch_ack), .ch_queue(ch_queue), .ch_index(ch_index), .rd_adv(rd_adv)
    );

    localparam logic [5:0] A_EN = 6'd0, A_EMP = 6'd1, A_CHAIN = 6'd2;
    function automatic logic [5:0] a_wr(int q); return 6'(16 + q); endfunction
    function automatic logic [5:0] a_rd(int q); return 6'(32 + q); endfunction
    function automatic logic [5:0] a_st(int q); return 6'(48 + q); endfunction
    function automatic logic [31:0] st_all(int act, int ch, int wsl, int mode);
        return (32'h3FF << 10) | 32'(act) | (32'(ch) << 1) | (32'(wsl) << 5) | (32'(mode) << 8);
    endfunction

    task automatic chk(bit ok, string req, longint act, longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    task automatic wreg(logic [5:0] a, logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rreg(logic [5:0] a, logic [31:0] exp, string req);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(reg_rdata == exp, req, reg_rdata, exp);
    endtask

    task automatic push(int ch, int q, int idx, bit adv);
        exp_t e;
        e.ch = ch; e.q = q; e.idx = idx; e.adv = adv;
        sb.push_back(e);
    endtask

    task automatic drain(string req);
        int n = 0;
        while (sb.size() > 0 && n < 300) begin
            @(negedge clk);
            n++;
        end
        repeat (3) @(negedge clk);
        chk(sb.size() == 0, req, sb.size(), 0);
    endtask

    // monitor: samples 1 ns before each rising edge
    initial begin
        bit prev_acc = 1'b0;
        forever begin
            logic [7:0] hits;
            @(negedge clk);
            #4;
            if (!rst_n) begin
                prev_acc = 1'b0;
                continue;
            end
            hits = ch_req & ch_ack;
            if (prev_acc) chk(ch_req == 8'h00, "R12 idle after accept", ch_req, 0);
            prev_acc = |hits;
            if (|hits) begin
                int win = 0;
                for (int c = 0; c < 8; c++) if (hits[c]) win = c;
                if (sb.size() == 0) begin
                    chk(1'b0, "R5 unexpected transfer", win, -1);
                end else begin
                    exp_t e;
                    logic [15:0] adv_exp;
                    e = sb.pop_front();
                    adv_exp = e.adv ? (16'h1 << e.q) : 16'h0;
                    chk(win == e.ch, "R8 winning channel", win, e.ch);
                    chk(int'(ch_queue[win*4 +: 4]) == e.q, "R7 granted queue",
                        ch_queue[win*4 +: 4], e.q);
                    chk(int'(ch_index[win*8 +: 8]) == e.idx, "R5 descriptor index",
                        ch_index[win*8 +: 8], e.idx);
                    chk(rd_adv == adv_exp, "R6 read-advance pulse", rd_adv, adv_exp);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        @(negedge clk); #1;
        chk(ch_req == 8'h00, "R1 no request", ch_req, 0);
        rreg(A_EN, 32'hFF, "R1 enable");
        rreg(A_EMP, 32'hFFFF, "R1 empty");
        rreg(A_CHAIN, 32'h0, "R1 chain");
        rreg(a_st(3), 32'h0, "R1 status");
        rreg(a_wr(3), 32'h0, "R1 write index");

        // R2 masked status write
        wreg(a_st(2), (32'h1 << 10) | 32'h3FF);
        rreg(a_st(2), 32'h001, "R2 masked status");
        wreg(a_st(2), 32'h1 << 10);
        rreg(a_st(2), 32'h000, "R2 masked clear");

        // R10 masked empty write
        wreg(A_EMP, 32'hFFFF_0000);
        rreg(A_EMP, 32'h0, "R10 empty masked write");

        // R3 R5 R6 in-order queue 0 on channel 1
        wreg(a_st(0), st_all(1, 1, 0, 0));
        wreg(a_wr(0), 3);
        push(1, 0, 0, 1); push(1, 0, 1, 1); push(1, 0, 2, 1);
        ch_ack = 8'hFF;
        drain("R5 in-order drain");
        ch_ack = 8'h00;
        rreg(a_rd(0), 32'd3, "R6 read index advanced");
        rreg(A_EMP, 32'h0001, "R10 drained queue flagged");

        // R7 round robin on channel 2
        wreg(a_st(4), st_all(1, 2, 0, 0));
        wreg(a_st(5), st_all(1, 2, 0, 0));
        wreg(a_wr(4), 2);
        wreg(a_wr(5), 2);
        push(2, 4, 0, 1); push(2, 5, 0, 1); push(2, 4, 1, 1); push(2, 5, 1, 1);
        ch_ack = 8'hFF;
        drain("R7 round robin");
        ch_ack = 8'h00;

        // R8 channel priority; bit 4 of channel field ignored for queue 7 (11 -> 3)
        wreg(a_st(6), st_all(1, 0, 0, 0));
        wreg(a_wr(6), 1);
        wreg(a_st(7), st_all(1, 11, 0, 0));
        wreg(a_wr(7), 1);
        repeat (2) @(negedge clk); #1;
        chk(ch_req == 8'b0000_1001, "R8 R12 both raised", ch_req, 8'b0000_1001);
        push(3, 7, 0, 1); push(0, 6, 0, 1);
        ch_ack = 8'hFF;
        drain("R8 priority order");

        // R4 channel enable gating
        wreg(A_EN, 32'hDF);
        wreg(a_st(8), st_all(1, 5, 0, 0));
        wreg(a_wr(8), 1);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk); #1;
            chk(ch_req[5] == 1'b0, "R4 disabled channel silent", ch_req, 0);
        end
        push(5, 8, 0, 1);
        wreg(A_EN, 32'hFF);
        drain("R4 enabled channel served");
        ch_ack = 8'h00;

        // R9 acknowledgement-tracking queue 9 on channel 4
        wreg(a_st(9), st_all(1, 4, 1, 1));
        wreg(a_wr(9), 3);
        repeat (3) @(negedge clk); #1;
        chk(ch_req == 8'h00, "R9 no chain no request", ch_req, 0);
        wreg(A_CHAIN, 32'h1 << 9);
        push(4, 9, 0, 0);
        ch_ack = 8'hFF;
        drain("R9 ack-mode grant");
        rreg(a_st(9), 32'h109, "R9 window flag cleared");
        rreg(a_rd(9), 32'd0, "R9 read index held");
        push(4, 9, 0, 0);
        wreg(a_st(9), (32'h1 << 15) | (32'h1 << 5));
        drain("R9 re-armed grant");
        ch_ack = 8'h00;

        // R11 host write collides with accept on the same read index
        wreg(a_st(10), st_all(1, 6, 0, 0));
        wreg(a_wr(10), 5);
        repeat (2) @(negedge clk); #1;
        chk(ch_req == 8'h40, "R11 offer ready", ch_req, 8'h40);
        push(6, 10, 0, 1); push(6, 10, 4, 1);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a_rd(10); reg_wdata = 32'd4; ch_ack = 8'h40;
        @(negedge clk);
        reg_we = 1'b0;
        drain("R11 host value kept");
        ch_ack = 8'h00;
        rreg(a_rd(10), 32'd5, "R11 final read index");

        finish_up();
    end
endmodule